// File: doc/BRIEF.md
# Processor Control Input Conditioner

This block sits between three asynchronous control pins and a small 16-bit processor core. The pins are a wait-test level, a non-maskable interrupt line and a reset request. Each pin passes through a multi-stage synchronizer into the core clock domain before any logic uses it.

The reset request becomes a core reset only after it has stayed high long enough. Shorter glitches are discarded. When a qualified reset is released, the block emits a single-cycle restart strobe.

A rising edge on the interrupt line is captured into a sticky pending flag. No software mask or enable can block this flag. It is offered to the core as a type-2 request only while the core signals an instruction boundary, and it clears when the core reports that the interrupt was taken. The synchronized test level, combined with the core's wait-instruction flag, produces a stall that holds the core idle until the test input goes low.

Top module: `pin_conditioner`

## Requirements
- R1: With `waitActive` high, `stall` goes high exactly two clock edges after `testPin` rises. It is still low after the first edge.
- R2: `stall` is low whenever `waitActive` is low or the synchronized test level is low, whatever the other input is doing.
- R3: A low-to-high transition on `nmiPin` sets `nmiPending` on the third clock edge after the transition. A steady high level creates no further request after the flag has been acknowledged.
- R4: `nmiPending` stays set until an `nmiAck` pulse clears it. `nmiReq` is high only while `nmiPending` and `instrEnd` are both high. `nmiType` always reads 2. No input masks the request.
- R5: A second rising edge that arrives while `nmiPending` is still set is merged into it. A single `nmiAck` then leaves the flag clear.
- R6: If a new rising edge is detected in the same cycle as `nmiAck`, the new edge wins and `nmiPending` stays set.
- R7: A `resetPin` pulse lasting fewer than MIN_RST (default 4) clock cycles produces no `coreReset` and no `restartPulse`.
- R8: A `resetPin` pulse of N >= 4 cycles raises `coreReset` on the sixth edge after the pin rises. `coreReset` then stays high for N-3 cycles.
- R9: Exactly one `restartPulse` cycle follows a qualified reset. It is high in the cycle right after `coreReset` falls, which is edge N+3 for a pulse of N cycles.
- R10: While `coreReset` is high, `stall` is low and `nmiPending` is cleared. Interrupt edges seen during that time are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Power-on reset of the conditioner flops, active low |
| testPin | input | 1 | Raw wait-test level, asynchronous |
| nmiPin | input | 1 | Raw non-maskable interrupt line, asynchronous |
| resetPin | input | 1 | Raw reset request, asynchronous, active high |
| instrEnd | input | 1 | Core is at an instruction boundary |
| waitActive | input | 1 | Core is executing a wait instruction |
| nmiAck | input | 1 | One-cycle pulse: the pending interrupt was taken |
| coreReset | output | 1 | Qualified, synchronized core reset |
| restartPulse | output | 1 | One-cycle strobe when a qualified reset ends |
| nmiPending | output | 1 | Latched interrupt request |
| nmiReq | output | 1 | Interrupt offered at the current boundary |
| nmiType | output | 8 | Vector type of the interrupt, fixed at 2 |
| stall | output | 1 | Hold the core in its wait idle state |

## Verification
A stuck or mis-sequenced reset length counter shows at the ports as a `coreReset` whose rise edge or length is wrong by a cycle. It can also show as a three-cycle glitch that leaks through. Either is visible within about ten cycles of the pin change.

A wrong pending-flag state shows as a lost or doubled request. The bench reads it on `nmiPending` one edge after the acknowledge or edge that should have changed it. A synchronizer with the wrong depth moves `stall` and `nmiPending` by one edge, so both are sampled on the edge before and the edge of the expected change.

// File: rtl/pin_cond_pkg.sv
package pin_cond_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic rstSet;
    logic rstClr;
    logic restart;
    logic pendSet;
    logic pendClr;
  } strobeT;

  // state and synchronized levels from datapath to control
  typedef struct packed {
    logic testLvl;
    logic nmiRise;
    logic rstLvl;
    logic rstQual;
    logic coreRst;
    logic pend;
    logic restart;
  } statusT;

endpackage

// File: rtl/pin_cond_dp.sv
module pin_cond_dp
  import pin_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RST     = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   testPin,
  input  logic   nmiPin,
  input  logic   resetPin,
  input  strobeT strb,
  output statusT stat
);

  localparam int NLINES  = 3;
  localparam int CNT_W   = (MIN_RST > 2) ? $clog2(MIN_RST) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_RST - 1);

  logic [NLINES-1:0] rawIn;
  logic [NLINES-1:0] syncLvl;
  logic              nmiPrev;
  logic [CNT_W-1:0]  rstCnt;
  logic              coreRstQ;
  logic              pendQ;
  logic              restartQ;

  assign rawIn = {resetPin, nmiPin, testPin};

  // one synchronizer chain per pin
  for (genvar l = 0; l < NLINES; l++) begin : gLine
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], rawIn[l]};
    end
    assign syncLvl[l] = chain[SYNC_STAGES-1];
  end

  // extra stage for edge detection on the interrupt line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nmiPrev <= 1'b0;
    else       nmiPrev <= syncLvl[1];
  end

  // reset length counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                rstCnt <= '0;
    else if (strb.cntClr)                     rstCnt <= '0;
    else if (strb.cntInc && rstCnt != CNT_MAX) rstCnt <= rstCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            coreRstQ <= 1'b0;
    else if (strb.rstSet) coreRstQ <= 1'b1;
    else if (strb.rstClr) coreRstQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) restartQ <= 1'b0;
    else       restartQ <= strb.restart;
  end

  // sticky interrupt flag: a new edge wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pendQ <= 1'b0;
    else if (strb.pendSet) pendQ <= 1'b1;
    else if (strb.pendClr) pendQ <= 1'b0;
  end

  always_comb begin
    stat.testLvl = syncLvl[0];
    stat.nmiRise = syncLvl[1] & ~nmiPrev;
    stat.rstLvl  = syncLvl[2];
    stat.rstQual = (rstCnt == CNT_MAX);
    stat.coreRst = coreRstQ;
    stat.pend    = pendQ;
    stat.restart = restartQ;
  end

endmodule

// File: rtl/pin_cond_ctl.sv
module pin_cond_ctl
  import pin_cond_pkg::*;
(
  input  statusT stat,
  input  logic   instrEnd,
  input  logic   waitActive,
  input  logic   nmiAck,
  output strobeT strb,
  output logic   nmiReq,
  output logic   stall
);

  always_comb begin
    strb.cntInc  = stat.rstLvl;
    strb.cntClr  = ~stat.rstLvl;
    strb.rstSet  = stat.rstLvl & stat.rstQual;
    strb.rstClr  = ~stat.rstLvl;
    strb.restart = stat.coreRst & ~stat.rstLvl;
    strb.pendSet = stat.nmiRise & ~stat.coreRst;
    strb.pendClr = stat.coreRst | nmiAck;
  end

  always_comb begin
    nmiReq = stat.pend & instrEnd & ~stat.coreRst;
    stall  = waitActive & stat.testLvl & ~stat.coreRst;
  end

endmodule

// File: rtl/pin_conditioner.sv
module pin_conditioner
  import pin_cond_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          MIN_RST     = 4,
  parameter logic [7:0]  NMI_TYPE    = 8'd2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       testPin,
  input  logic       nmiPin,
  input  logic       resetPin,
  input  logic       instrEnd,
  input  logic       waitActive,
  input  logic       nmiAck,
  output logic       coreReset,
  output logic       restartPulse,
  output logic       nmiPending,
  output logic       nmiReq,
  output logic [7:0] nmiType,
  output logic       stall
);

  strobeT strb;
  statusT stat;

  pin_cond_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_RST    (MIN_RST)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .testPin (testPin),
    .nmiPin  (nmiPin),
    .resetPin(resetPin),
    .strb    (strb),
    .stat    (stat)
  );

  pin_cond_ctl u_ctl (
    .stat      (stat),
    .instrEnd  (instrEnd),
    .waitActive(waitActive),
    .nmiAck    (nmiAck),
    .strb      (strb),
    .nmiReq    (nmiReq),
    .stall     (stall)
  );

  assign coreReset    = stat.coreRst;
  assign restartPulse = stat.restart;
  assign nmiPending   = stat.pend;
  assign nmiType      = NMI_TYPE;

endmodule

// File: rtl/pin_cond_chk.sv
module pin_cond_chk #(
  parameter int MIN_RST = 4
) (
  input logic clk,
  input logic rstN,
  input logic rstLvl,
  input logic nmiRise,
  input logic nmiAck,
  input logic coreReset,
  input logic restartPulse,
  input logic nmiPending
);

  localparam int RUN_W = $clog2(MIN_RST + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_RST);

  logic [RUN_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               runCnt <= '0;
    else if (!rstLvl)        runCnt <= '0;
    else if (runCnt != RUN_MAX) runCnt <= runCnt + 1'b1;
  end

  AST_RST_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreReset) |-> runCnt >= RUN_MAX);                     // R8

  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    restartPulse |=> !restartPulse);                              // R9

  AST_RESTART_AFTER_RST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(restartPulse) |-> $past(coreReset) && !coreReset);      // R9

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    nmiPending && !nmiAck && !coreReset |=> nmiPending);          // R4

  AST_PEND_FROM_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiPending) |-> $past(nmiRise));                        // R3

  AST_RST_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    coreReset |=> !nmiPending);                                   // R10

endmodule

bind pin_conditioner pin_cond_chk #(.MIN_RST(MIN_RST)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .rstLvl      (stat.rstLvl),
  .nmiRise     (stat.nmiRise),
  .nmiAck      (nmiAck),
  .coreReset   (coreReset),
  .restartPulse(restartPulse),
  .nmiPending  (nmiPending)
);

// File: tb/pin_conditioner_bench.sv
module pin_conditioner_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN, testPin, nmiPin, resetPin, instrEnd, waitActive, nmiAck;
  logic coreReset, restartPulse, nmiPending, nmiReq, stall;
  logic [7:0] nmiType;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_conditioner u_pin_conditioner (
    .clk(clk), .rstN(rstN), .testPin(testPin), .nmiPin(nmiPin),
    .resetPin(resetPin), .instrEnd(instrEnd), .waitActive(waitActive),
    .nmiAck(nmiAck), .coreReset(coreReset), .restartPulse(restartPulse),
    .nmiPending(nmiPending), .nmiReq(nmiReq), .nmiType(nmiType),
    .stall(stall)
  );

  // {waitActive, testPin, expected stall}
  localparam logic [2:0] STALL_VEC [8] = '{
    3'b000, 3'b010, 3'b100, 3'b111, 3'b010, 3'b111, 3'b100, 3'b000
  };

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // reset pin high for n cycles; optional interrupt edge after edge nmiAt
  task automatic rstRun(int n, int nmiAt, output int first, output int highs,
                        output int pulses, output int pulseAt, output int stallBad);
    first = 0; highs = 0; pulses = 0; pulseAt = 0; stallBad = 0;
    resetPin = 1'b1;
    for (int k = 1; k <= n + 12; k++) begin
      step(1);
      if (coreReset) begin
        if (first == 0) first = k;
        highs++;
        if (stall) stallBad++;
      end
      if (restartPulse) begin
        pulses++;
        pulseAt = k;
      end
      if (k == n) resetPin = 1'b0;
      if (k == nmiAt) nmiPin = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    int first, highs, pulses, pulseAt, stallBad;
    rstN = 1'b0; testPin = 1'b0; nmiPin = 1'b0; resetPin = 1'b0;
    instrEnd = 1'b0; waitActive = 1'b0; nmiAck = 1'b0;
    step(2);
    chk("R8", "reset coreReset", coreReset, 0);
    chk("R9", "reset restartPulse", restartPulse, 0);
    chk("R3", "reset nmiPending", nmiPending, 0);
    chk("R2", "reset stall", stall, 0);
    chk("R4", "nmiType", nmiType, 2);
    rstN = 1'b1;
    step(2);

    // stall table: R1 / R2
    for (int i = 0; i < 8; i++) begin
      waitActive = STALL_VEC[i][2];
      testPin    = STALL_VEC[i][1];
      step(3);
      chk(STALL_VEC[i][0] ? "R1" : "R2", $sformatf("stall vector %0d", i),
          stall, STALL_VEC[i][0]);
    end

    // R1 latency
    waitActive = 1'b1; testPin = 1'b0; step(3);
    testPin = 1'b1;
    step(1); chk("R1", "stall after one edge", stall, 0);
    step(1); chk("R1", "stall after two edges", stall, 1);
    testPin = 1'b0; waitActive = 1'b0; step(3);

    // R3 edge latency
    nmiPin = 1'b1;
    step(2); chk("R3", "pending after two edges", nmiPending, 0);
    step(1); chk("R3", "pending after three edges", nmiPending, 1);
    // R4 boundary gating
    chk("R4", "nmiReq without boundary", nmiReq, 0);
    instrEnd = 1'b1; #1;
    chk("R4", "nmiReq at boundary", nmiReq, 1);
    step(1); instrEnd = 1'b0;
    step(3); chk("R4", "pending held without ack", nmiPending, 1);
    nmiAck = 1'b1; step(1); nmiAck = 1'b0;
    chk("R4", "pending cleared by ack", nmiPending, 0);
    step(5); chk("R3", "steady high no retrigger", nmiPending, 0);

    // R5 merge
    nmiPin = 1'b0; step(4);
    nmiPin = 1'b1; step(4);
    nmiPin = 1'b0; step(4);
    nmiPin = 1'b1; step(4);
    chk("R5", "pending after two edges", nmiPending, 1);
    nmiAck = 1'b1; step(1); nmiAck = 1'b0;
    step(4); chk("R5", "single ack clears merged", nmiPending, 0);

    // R6 edge and ack same cycle
    nmiPin = 1'b0; step(4);
    nmiPin = 1'b1; step(4);
    nmiPin = 1'b0; step(4);
    chk("R6", "pending before collision", nmiPending, 1);
    nmiPin = 1'b1; step(2);
    nmiAck = 1'b1; step(1); nmiAck = 1'b0;
    chk("R6", "edge wins over ack", nmiPending, 1);
    nmiAck = 1'b1; step(1); nmiAck = 1'b0;
    chk("R6", "later ack clears", nmiPending, 0);

    // R7 short reset pulses
    for (int n = 2; n <= 3; n++) begin
      rstRun(n, 0, first, highs, pulses, pulseAt, stallBad);
      chk("R7", $sformatf("coreReset cycles for %0d", n), highs, 0);
      chk("R7", $sformatf("restart pulses for %0d", n), pulses, 0);
    end

    // R8 / R9 qualified pulses
    for (int n = 4; n <= 7; n += 3) begin
      rstRun(n, 0, first, highs, pulses, pulseAt, stallBad);
      chk("R8", $sformatf("coreReset rise edge for %0d", n), first, 6);
      chk("R8", $sformatf("coreReset cycles for %0d", n), highs, n - 3);
      chk("R9", $sformatf("restart count for %0d", n), pulses, 1);
      chk("R9", $sformatf("restart edge for %0d", n), pulseAt, n + 3);
    end

    // R10 reset clears pending, forces stall low, drops edges
    nmiPin = 1'b0; step(4);
    nmiPin = 1'b1; step(4);
    nmiPin = 1'b0; step(4);
    waitActive = 1'b1; testPin = 1'b1; step(3);
    chk("R10", "pending before reset", nmiPending, 1);
    chk("R10", "stall before reset", stall, 1);
    rstRun(10, 6, first, highs, pulses, pulseAt, stallBad);
    chk("R10", "stall high during reset", stallBad, 0);
    chk("R10", "pending after reset", nmiPending, 0);
    chk("R10", "stall back after reset", stall, 1);
    chk("R8", "coreReset cycles for 10", highs, 7);

    finishRun();
  end

endmodule